// File: doc/BRIEF.md
# Protected Top-of-RAM Region Guard

The guard keeps two byte-wide control registers and filters every memory request on its way to DRAM. Software reaches the registers through a small configuration port. The control register holds an open bit, a closed bit, a sticky lock bit and a global enable. The region register holds a region-enable bit and a two-bit size selector. From these the guard computes a protected window that ends at the top of RAM. Ordinary-mode requests that fall in the window are stopped: a read returns all-ones and a write never reaches DRAM. Requests made in the privileged management mode, and all requests while protection is off, pass through unchanged.

Firmware sets the size, the region enable, the closed bit and the global enable, and then sets the lock in a later write. After that the configuration cannot change until the next reset. Register reads and the request filter are combinational. Register writes take effect at the clock edge.

Top module: `smram_guard`

## Requirements
- R1: After reset the control register (config address 0x20) reads 0x00 and the region register (config address 0x21) reads 0x04, which is size selector 2'b10.
- R2: While the lock (control bit 2) is clear, writes to control bit 0 (open) set or clear it, and a read returns the written value.
- R3: A control write with bit 2 set stores the lock and leaves the open bit at zero, even when the same write sets bit 0.
- R4: While locked, writes to either register have no effect, and the open bit reads back as zero.
- R5: Reset clears the lock, after which the open bit is writable again.
- R6: The region size comes from bits [2:1] of the region register: 00 gives 1 MB, 01 gives 2 MB, 10 gives 8 MB, and 11 gives EXT_MB megabytes. The window base is RAM_MB·2^20 minus the size, and the byte at base−1 is passed as normal memory.
- R7: Protection is active when global enable (control bit 3), closed (control bit 1) and region enable (region bit 0) are all set. While it is active, a non-management-mode request at or above the base has its DRAM valid held low, and its read data is 0xFF.
- R8: While protection is inactive, and for any request with reqSmm high, the request passes: dramValid follows reqValid and reqRdata equals dramRdata.
- R9: Undefined register bits (control [7:4], region [7:3]) read as zero whatever is written, and an unmapped configuration address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgAddr | input | 8 | Configuration register address |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data (combinational) |
| reqValid | input | 1 | Memory request valid |
| reqWrite | input | 1 | Memory request is a write |
| reqAddr | input | AW | Memory byte address |
| reqWdata | input | 8 | Memory write data |
| reqSmm | input | 1 | Request issued in management mode |
| reqRdata | output | 8 | Read data returned to requester |
| dramValid | output | 1 | Request forwarded to DRAM |
| dramWrite | output | 1 | Forwarded write flag |
| dramAddr | output | AW | Forwarded address |
| dramWdata | output | 8 | Forwarded write data |
| dramRdata | input | 8 | Read data from DRAM |

## Verification
The bench writes open and lock together in one write. A design that stored the open bit there would read 0x0F where 0x0E is expected. After locking, the bench tries to reopen the region and to resize it. A guard that failed to freeze either register would read back the new value. In each of the four size encodings the bench probes the first byte of the window and the byte just below it. An off-by-one base, or a swapped decode, shows up as a blocked or a leaking byte. Finally, the bench repeats window accesses in management mode and with the closed bit cleared. A filter that ignored either condition would return 0xFF where DRAM data is expected.

// File: rtl/smg_pkg.sv
package smg_pkg;
  // control register bit positions
  localparam int CtlOpen   = 0;
  localparam int CtlClosed = 1;
  localparam int CtlLock   = 2;
  localparam int CtlGlobal = 3;
  localparam logic [7:0] CtlMask = 8'h0F;
  // region register
  localparam int RegEn     = 0;
  localparam logic [7:0] RegMask = 8'h07;

  typedef struct packed {
    logic       block;    // protection active
    logic [1:0] sizeSel;  // size selector
  } guard_ctl_t;
endpackage

// File: rtl/smg_ctrl.sv
module smg_ctrl import smg_pkg::*; #(
  parameter int CAW = 8,
  parameter logic [CAW-1:0] CTL_ADDR = 8'h20,
  parameter logic [CAW-1:0] REG_ADDR = 8'h21,
  parameter logic [1:0] DEF_SIZE = 2'b10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CAW-1:0] cfgAddr,
  input  logic           cfgWe,
  input  logic [7:0]     cfgWdata,
  output logic [7:0]     cfgRdata,
  output logic [7:0]     ctlReg,
  output logic [7:0]     extReg,
  output guard_ctl_t     strobes
);
  localparam logic [7:0] RegReset = {5'b0, DEF_SIZE, 1'b0};

  logic locked;
  logic [7:0] ctlNext;

  assign locked = ctlReg[CtlLock];

  always_comb begin
    ctlNext = cfgWdata & CtlMask;
    if (ctlNext[CtlLock]) ctlNext[CtlOpen] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= 8'h00;
      extReg <= RegReset;
    end else if (cfgWe && !locked) begin
      if (cfgAddr == CTL_ADDR) ctlReg <= ctlNext;
      if (cfgAddr == REG_ADDR) extReg <= cfgWdata & RegMask;
    end
  end

  always_comb begin
    if (cfgAddr == CTL_ADDR)      cfgRdata = ctlReg;
    else if (cfgAddr == REG_ADDR) cfgRdata = extReg;
    else                          cfgRdata = 8'h00;
  end

  assign strobes.block   = ctlReg[CtlGlobal] & ctlReg[CtlClosed] & extReg[RegEn];
  assign strobes.sizeSel = extReg[2:1];
endmodule

// File: rtl/smg_path.sv
module smg_path import smg_pkg::*; #(
  parameter int RAM_MB = 128,
  parameter int EXT_MB = 16,
  parameter int AW = $clog2(RAM_MB) + 20
) (
  input  guard_ctl_t    strobes,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqWdata,
  input  logic          reqSmm,
  output logic [7:0]    reqRdata,
  output logic          dramValid,
  output logic          dramWrite,
  output logic [AW-1:0] dramAddr,
  output logic [7:0]    dramWdata,
  input  logic [7:0]    dramRdata
);
  localparam int MBW = $clog2(RAM_MB) + 1;
  localparam logic [AW:0] RamBytes = (AW+1)'(RAM_MB) << 20;

  logic [MBW-1:0] sizeMb;
  logic [AW:0]    regionBytes;
  logic [AW:0]    baseAddr;
  logic           hit;

  always_comb begin
    case (strobes.sizeSel)
      2'b00:   sizeMb = MBW'(1);
      2'b01:   sizeMb = MBW'(2);
      2'b10:   sizeMb = MBW'(8);
      default: sizeMb = MBW'(EXT_MB);
    endcase
  end

  assign regionBytes = (AW+1)'(sizeMb) << 20;
  assign baseAddr    = RamBytes - regionBytes;
  assign hit = reqValid && strobes.block && !reqSmm && ({1'b0, reqAddr} >= baseAddr);

  assign dramValid = reqValid && !hit;
  assign dramWrite = reqWrite;
  assign dramAddr  = reqAddr;
  assign dramWdata = reqWdata;
  assign reqRdata  = hit ? 8'hFF : dramRdata;
endmodule

// File: rtl/smram_guard.sv
module smram_guard import smg_pkg::*; #(
  parameter int RAM_MB = 128,
  parameter int EXT_MB = 16,
  parameter int AW = $clog2(RAM_MB) + 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    cfgAddr,
  input  logic          cfgWe,
  input  logic [7:0]    cfgWdata,
  output logic [7:0]    cfgRdata,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqWdata,
  input  logic          reqSmm,
  output logic [7:0]    reqRdata,
  output logic          dramValid,
  output logic          dramWrite,
  output logic [AW-1:0] dramAddr,
  output logic [7:0]    dramWdata,
  input  logic [7:0]    dramRdata
);
  guard_ctl_t strobes;
  logic [7:0] ctlReg;
  logic [7:0] extReg;

  smg_ctrl #(.CAW(8)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .ctlReg(ctlReg),
    .extReg(extReg), .strobes(strobes)
  );

  smg_path #(.RAM_MB(RAM_MB), .EXT_MB(EXT_MB), .AW(AW)) uPath (
    .strobes(strobes), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSmm(reqSmm),
    .reqRdata(reqRdata), .dramValid(dramValid), .dramWrite(dramWrite),
    .dramAddr(dramAddr), .dramWdata(dramWdata), .dramRdata(dramRdata)
  );
endmodule

// File: rtl/smg_chk.sv
module smg_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctlReg,
  input logic [7:0] extReg,
  input logic       reqValid,
  input logic       reqSmm,
  input logic       dramValid,
  input logic [7:0] reqRdata
);
  a_r3_lock_forces_closed_open: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[2] |-> !ctlReg[0]);
  a_r4_regs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[2] |=> ($stable(ctlReg) && $stable(extReg)));
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[2] |=> ctlReg[2]);
  a_r7_blocked_reads_ones: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !dramValid) |-> (reqRdata == 8'hFF));
  a_r8_smm_passes: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSmm) |-> dramValid);
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg[7:4] == 4'h0) && (extReg[7:3] == 5'h00));
endmodule

bind smram_guard smg_chk u_chk (
  .clk(clk), .rstN(rstN), .ctlReg(ctlReg), .extReg(extReg),
  .reqValid(reqValid), .reqSmm(reqSmm), .dramValid(dramValid),
  .reqRdata(reqRdata)
);

// File: tb/sim_smram_guard.sv
`timescale 1ns/1ps
module sim_smram_guard;
  localparam int AW = 27;
  localparam logic [7:0] CTL = 8'h20;
  localparam logic [7:0] RGN = 8'h21;
  localparam logic [7:0] DRAMV = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgAddr = '0, cfgWdata = '0, cfgRdata;
  logic cfgWe = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSmm = 1'b0;
  logic [AW-1:0] reqAddr = '0, dramAddr;
  logic [7:0] reqWdata = '0, reqRdata, dramWdata;
  logic dramValid, dramWrite;
  logic [7:0] dramRdata = DRAMV;

  always #2 clk = ~clk;

  smram_guard u0 (.*);

  typedef struct {
    bit         isMem;
    string      tag;
    logic [7:0] e8;
    logic       eValid;
    bit         chkData;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (!it.isMem) begin
        if (cfgRdata !== it.e8) begin
          fails++;
          $display("FAIL %s cfgRdata actual %h expected %h", it.tag, cfgRdata, it.e8);
        end
      end else begin
        if (dramValid !== it.eValid || (it.chkData && reqRdata !== it.e8) || dramAddr !== reqAddr) begin
          fails++;
          $display("FAIL %s dramValid/reqRdata actual %b/%h expected %b/%h",
                   it.tag, dramValid, reqRdata, it.eValid, it.e8);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    cfgWe = 0; reqValid = 0;
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reqValid = 0; cfgAddr = a; cfgWdata = d; cfgWe = 1;
  endtask

  task automatic cfgRd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    reqValid = 0; cfgWe = 0; cfgAddr = a;
    it.isMem = 0; it.tag = tag; it.e8 = exp; it.eValid = 0; it.chkData = 1;
    q.push_back(it);
  endtask

  task automatic memAcc(input logic [AW-1:0] a, input bit wr, input bit smm,
                        input bit expPass, input string tag);
    item_t it;
    @(posedge clk); #1;
    cfgWe = 0; reqValid = 1; reqWrite = wr; reqAddr = a; reqSmm = smm; reqWdata = 8'h32;
    it.isMem = 1; it.tag = tag; it.eValid = expPass;
    it.e8 = expPass ? DRAMV : 8'hFF; it.chkData = !wr;
    q.push_back(it);
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    cfgWe = 0; reqValid = 0; rstN = 0;
    @(posedge clk); @(posedge clk); #1;
    rstN = 1;
  endtask

  task automatic sizeCase(input logic [7:0] rgnVal, input int mb, input string tag);
    logic [AW-1:0] base;
    base = AW'((128 - mb) << 20);
    cfgWr(RGN, rgnVal);
    cfgWr(CTL, 8'h0A);
    memAcc(base - 1, 0, 0, 1, {tag, " below base"});
    memAcc(base, 0, 0, 0, {tag, " at base"});
  endtask

  initial begin
    doReset();
    cfgRd(CTL, 8'h00, "R1 ctl reset");
    cfgRd(RGN, 8'h04, "R1 region reset");
    cfgWr(CTL, 8'h01);
    cfgRd(CTL, 8'h01, "R2 open set");
    cfgWr(CTL, 8'h00);
    cfgRd(CTL, 8'h00, "R2 open clear");
    cfgWr(CTL, 8'hF1);
    cfgRd(CTL, 8'h01, "R9 ctl reserved");
    cfgWr(RGN, 8'hFE);
    cfgRd(RGN, 8'h06, "R9 region reserved");
    cfgRd(8'h44, 8'h00, "R9 unmapped");
    // protection off: top byte passes
    memAcc(AW'(32'h7FFFFFF), 0, 0, 1, "R8 off passes");
    // program 1 MB window, then lock together with open
    cfgWr(RGN, 8'h01);
    cfgWr(CTL, 8'h0A);
    cfgWr(CTL, 8'h0F);
    cfgRd(CTL, 8'h0E, "R3 lock clears open");
    cfgWr(CTL, 8'h01);
    cfgRd(CTL, 8'h0E, "R4 open not settable");
    cfgWr(RGN, 8'h07);
    cfgRd(RGN, 8'h01, "R4 region frozen");
    memAcc(AW'(32'h7EFFFFF), 0, 0, 1, "R6 1MB below base");
    memAcc(AW'(32'h7F00000), 0, 0, 0, "R7 read blocked");
    memAcc(AW'(32'h7F00000), 1, 0, 0, "R7 write dropped");
    memAcc(AW'(32'h7FFFFFF), 0, 0, 0, "R7 top byte blocked");
    memAcc(AW'(32'h7F00000), 0, 1, 1, "R8 smm read passes");
    memAcc(AW'(32'h7F00000), 1, 1, 1, "R8 smm write passes");
    doReset();
    cfgRd(CTL, 8'h00, "R5 lock cleared");
    cfgWr(CTL, 8'h01);
    cfgRd(CTL, 8'h01, "R5 open writable");
    sizeCase(8'h03, 2, "R6 2MB");
    sizeCase(8'h05, 8, "R6 8MB");
    sizeCase(8'h07, 16, "R6 ext 16MB");
    sizeCase(8'h01, 1, "R6 1MB unlocked");
    cfgWr(CTL, 8'h08);
    memAcc(AW'(32'h7F00000), 0, 0, 1, "R8 not closed passes");
    cfgWr(CTL, 8'h0A);
    cfgWr(RGN, 8'h00);
    memAcc(AW'(32'h7F00000), 0, 0, 1, "R8 region disabled passes");
    idle();
    idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule